// File: doc/BRIEF.md
# Dual-Channel Disk Controller Register File

This block is the memory-mapped control and status register file of a two-channel disk interface controller with bus-master DMA. Software reaches it through a 512-byte window, one request per register. Each channel holds a DMA command byte, a DMA status byte, a 6-bit scratch byte for software, a configuration/status word, a serial control word and an interrupt enable word. Two read-only words pack state from both channels together, so that one read returns the status of the whole controller.

Requests arrive on a valid/ready stream. A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. A write takes effect on that edge and returns no response. A read returns one response beat, which stays held with its data unchanged until `rsp_ready` is high. `req_ready` is low only while a response is waiting and `rsp_ready` is low, so there is never more than one read outstanding.

Other parts of the controller connect through plain pins. These are a status-event strobe from each channel's DMA engine, each channel's interrupt level and device-present flag, the command bytes going out, a reset pulse for each channel and one combined interrupt line.

Top module: `dcr_top`

## Requirements
- R1: A read accepted on edge k raises `rsp_valid` after edge k with the register value as it was before edge k. While `rsp_ready` is low, `rsp_valid` and `rsp_data` stay unchanged and `req_ready` is low. A write accepted on edge k is visible to a read accepted on edge k+1.
- R2: The DMA status bytes sit at 0x02 (channel 0) and 0x0A (channel 1). A write to one of them behaves as follows: bits 6:5 take the written value, bit 0 keeps its old value, bits 2:1 clear where the written bit is 1 and keep their value where it is 0, and bits 7, 4 and 3 become 0.
- R3: The software bytes sit at 0x01 and 0x09. A write keeps only the written bits 5:0, and a read returns them with bits 7:6 as zero.
- R4: The DMA command bytes sit at 0x00 and 0x08, and `dma_cmd_o[8*c+7:8*c]` shows channel c's byte. Writes at 0x10, 0x11 and 0x12 update channel 0's command, software and status bytes. Writes at 0x18, 0x19 and 0x1A do the same for channel 1.
- R5: A read at 0x10 returns the following packed word: channel 0 command in bits 7:0, the channel 0 interrupt flag in bit 4, the channel 1 interrupt flag in bit 6, channel 1 status bit 2 in bit 14, channel 0 status in bits 23:16 and channel 1 status in bits 31:24.
- R6: A read at 0x18 returns channel 1 command in bits 7:0, the channel 1 interrupt flag in bit 4 and channel 1 status in bits 23:16.
- R7: Serial control sits at 0x100 and 0x180 and stores written bits 11:0. A write there with bit 0 set drives that channel's bit of `chan_rst_o` high for exactly one cycle after the write edge.
- R8: Interrupt enable sits at 0x148 and 0x1C8. A write stores written bits 31:16 ANDed with 0x3EED, and a read returns the stored value in bits 31:16.
- R9: Configuration/status sits at 0xA0 and 0xE0 and reads as 0x6515 in bits 31:16. Bit 11 is the channel's interrupt flag, which takes the value of `irq_lvl_i[c]` one edge later. All other bits read as 0.
- R10: `irq_o` is the OR of the two channels' interrupt flags.
- R11: Serial status sits at 0x104 and 0x184 and reads 0x113 when `dev_present_i[c]` is high and 0 otherwise.
- R12: Reserved bytes 0x03 and 0x0B and all unmapped offsets read as zero, and writes to them change no register.
- R13: While `rst_n` is low, both bits of `chan_rst_o` are high. After reset, every command, software, status, serial control and enable register reads 0 and `irq_o` is 0.
- R14: An engine strobe `eng_we_i[c]` with `eng_val_i[3c+2:3c]` sets status bit 0 to val[0] and ORs val[2:1] into status bits 2:1. This is applied after any register write that lands on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request ready |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_addr | input | 9 | Byte offset in the window |
| req_wdata | input | 32 | Write value |
| rsp_valid | output | 1 | Read response valid |
| rsp_ready | input | 1 | Read response ready |
| rsp_data | output | 32 | Read response data |
| irq_lvl_i | input | 2 | Interrupt level from each channel |
| dev_present_i | input | 2 | Device present flag for each channel |
| eng_we_i | input | 2 | DMA engine status event strobe for each channel |
| eng_val_i | input | 6 | Event bits, three per channel: active, error, interrupt |
| dma_cmd_o | output | 16 | DMA command byte for each channel |
| chan_rst_o | output | 2 | Reset pulse for each channel |
| irq_o | output | 1 | Combined interrupt |

## Verification
The bench builds the block with its default parameters: a 9-bit address, a 32-bit data path, identifier 0x6515, enable mask 0x3EED and present value 0x113. These are the values the fixed register offsets and packed words rely on. With these values the bench can read back both packed summary words after it has moved the status bytes of both channels through writes and engine events. It also holds `rsp_ready` low on a repeating pattern, so back-to-back reads meet back-pressure while several expected values are waiting in the scoreboard.

// File: rtl/dcr_pkg.sv
package dcr_pkg;
  localparam int NCH = 2;

  typedef struct packed {
    logic [7:0]  cmd;
    logic [5:0]  swd;
    logic [7:0]  stat;
    logic        irq;
    logic [11:0] sctl;
    logic [15:0] sien;
  } chan_view_t;

  function automatic int dma_base(input int ch);
    return ch * 8;
  endfunction

  function automatic int mirror_base(input int ch);
    return 16 + ch * 8;
  endfunction

  function automatic int conf_off(input int ch);
    return 160 + ch * 64;
  endfunction

  function automatic int serial_base(input int ch);
    return 256 + ch * 128;
  endfunction
endpackage

// File: rtl/dcr_port.sv
module dcr_port #(
  parameter int ADDR_W = 9,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              wr_en_o,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_data
);
  logic accept;

  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;
  assign wr_en_o   = accept && req_write;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else if (accept && !req_write) begin
      rsp_valid <= 1'b1;
      rsp_data  <= rd_data_i;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  // R1
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data));

  // R1
  single_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |-> !req_ready);
endmodule

// File: rtl/dcr_chan.sv
module dcr_chan
  import dcr_pkg::*;
#(
  parameter int          CH        = 0,
  parameter int          ADDR_W    = 9,
  parameter int          DATA_W    = 32,
  parameter logic [15:0] SIEN_MASK = 16'h3EED
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              irq_lvl,
  input  logic              eng_we,
  input  logic [2:0]        eng_val,
  output chan_view_t        view,
  output logic              chan_rst
);
  localparam logic [ADDR_W-1:0] CMD_A  = ADDR_W'(dma_base(CH));
  localparam logic [ADDR_W-1:0] SWD_A  = ADDR_W'(dma_base(CH) + 1);
  localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(dma_base(CH) + 2);
  localparam logic [ADDR_W-1:0] CMD_M  = ADDR_W'(mirror_base(CH));
  localparam logic [ADDR_W-1:0] SWD_M  = ADDR_W'(mirror_base(CH) + 1);
  localparam logic [ADDR_W-1:0] STAT_M = ADDR_W'(mirror_base(CH) + 2);
  localparam logic [ADDR_W-1:0] SCTL_A = ADDR_W'(serial_base(CH));
  localparam logic [ADDR_W-1:0] SIEN_A = ADDR_W'(serial_base(CH) + 72);

  logic [7:0]  cmd_q, stat_q, stat_d;
  logic [5:0]  swd_q;
  logic        irq_q, rst_q;
  logic [11:0] sctl_q;
  logic [15:0] sien_q;
  logic        wr_cmd, wr_swd, wr_stat, wr_sctl, wr_sien;

  assign wr_cmd  = wr_en && (addr == CMD_A  || addr == CMD_M);
  assign wr_swd  = wr_en && (addr == SWD_A  || addr == SWD_M);
  assign wr_stat = wr_en && (addr == STAT_A || addr == STAT_M);
  assign wr_sctl = wr_en && (addr == SCTL_A);
  assign wr_sien = wr_en && (addr == SIEN_A);

  always_comb begin
    stat_d = stat_q;
    if (wr_stat) begin
      stat_d = {1'b0, wdata[6:5], 2'b00, stat_q[2:1] & ~wdata[2:1], stat_q[0]};
    end
    if (eng_we) begin
      stat_d[0]   = eng_val[0];
      stat_d[2:1] = stat_d[2:1] | eng_val[2:1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q  <= '0;
      swd_q  <= '0;
      stat_q <= '0;
      irq_q  <= 1'b0;
      sctl_q <= '0;
      sien_q <= '0;
      rst_q  <= 1'b1;
    end else begin
      if (wr_cmd)  cmd_q  <= wdata[7:0];
      if (wr_swd)  swd_q  <= wdata[5:0];
      if (wr_sctl) sctl_q <= wdata[11:0];
      if (wr_sien) sien_q <= wdata[31:16] & SIEN_MASK;
      stat_q <= stat_d;
      irq_q  <= irq_lvl;
      rst_q  <= wr_sctl && wdata[0];
    end
  end

  assign view = '{cmd: cmd_q, swd: swd_q, stat: stat_q, irq: irq_q,
                  sctl: sctl_q, sien: sien_q};
  assign chan_rst = rst_q;

  // R2
  stat_active_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stat && !eng_we |=> stat_q[0] == $past(stat_q[0]));

  // R2
  stat_zero_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stat && !eng_we |=> stat_q[7] == 1'b0 && stat_q[4:3] == 2'b00);

  // R7
  rst_pulse_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_q && !(wr_sctl && wdata[0]) |=> !rst_q);

  // R9
  irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_lvl |=> irq_q);

  // R14
  eng_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eng_we && eng_val[2] |=> stat_q[2]);
endmodule

// File: rtl/dcr_rdmux.sv
module dcr_rdmux
  import dcr_pkg::*;
#(
  parameter int          ADDR_W    = 9,
  parameter int          DATA_W    = 32,
  parameter logic [15:0] CONF_ID   = 16'h6515,
  parameter logic [11:0] SSTAT_VAL = 12'h113
) (
  input  logic [ADDR_W-1:0]       addr,
  input  chan_view_t [NCH-1:0]    views,
  input  logic [NCH-1:0]          dev_present,
  output logic [DATA_W-1:0]       rdata
);
  localparam logic [ADDR_W-1:0] SUM0_A = ADDR_W'(mirror_base(0));
  localparam logic [ADDR_W-1:0] SUM1_A = ADDR_W'(mirror_base(1));

  always_comb begin
    rdata = '0;
    for (int ch = 0; ch < NCH; ch++) begin
      if (addr == ADDR_W'(dma_base(ch)))
        rdata = {24'b0, views[ch].cmd};
      if (addr == ADDR_W'(dma_base(ch) + 1))
        rdata = {26'b0, views[ch].swd};
      if (addr == ADDR_W'(dma_base(ch) + 2))
        rdata = {24'b0, views[ch].stat};
      if (addr == ADDR_W'(conf_off(ch)))
        rdata = {CONF_ID, 4'b0, views[ch].irq, 11'b0};
      if (addr == ADDR_W'(serial_base(ch)))
        rdata = {20'b0, views[ch].sctl};
      if (addr == ADDR_W'(serial_base(ch) + 4))
        rdata = dev_present[ch] ? {20'b0, SSTAT_VAL} : '0;
      if (addr == ADDR_W'(serial_base(ch) + 72))
        rdata = {views[ch].sien, 16'b0};
    end
    if (addr == SUM0_A) begin
      rdata = {views[1].stat, views[0].stat, 1'b0, views[1].stat[2], 6'b0,
               views[0].cmd};
      rdata[4] = views[0].irq;
      rdata[6] = views[1].irq;
    end
    if (addr == SUM1_A) begin
      rdata = {8'b0, views[1].stat, 8'b0, views[1].cmd};
      rdata[4] = views[1].irq;
    end
  end
endmodule

// File: rtl/dcr_top.sv
module dcr_top
  import dcr_pkg::*;
#(
  parameter int          ADDR_W    = 9,
  parameter int          DATA_W    = 32,
  parameter logic [15:0] CONF_ID   = 16'h6515,
  parameter logic [15:0] SIEN_MASK = 16'h3EED,
  parameter logic [11:0] SSTAT_VAL = 12'h113
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_data,
  input  logic [1:0]        irq_lvl_i,
  input  logic [1:0]        dev_present_i,
  input  logic [1:0]        eng_we_i,
  input  logic [5:0]        eng_val_i,
  output logic [15:0]       dma_cmd_o,
  output logic [1:0]        chan_rst_o,
  output logic              irq_o
);
  chan_view_t [NCH-1:0] views;
  logic [DATA_W-1:0]    rd_data;
  logic                 wr_en;

  dcr_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_port (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .rd_data_i(rd_data), .wr_en_o(wr_en),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    dcr_chan #(.CH(c), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
               .SIEN_MASK(SIEN_MASK)) u_chan (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(req_addr),
      .wdata(req_wdata), .irq_lvl(irq_lvl_i[c]), .eng_we(eng_we_i[c]),
      .eng_val(eng_val_i[3*c +: 3]), .view(views[c]), .chan_rst(chan_rst_o[c])
    );
    assign dma_cmd_o[8*c +: 8] = views[c].cmd;
  end

  dcr_rdmux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CONF_ID(CONF_ID),
              .SSTAT_VAL(SSTAT_VAL)) u_rdmux (
    .addr(req_addr), .views(views), .dev_present(dev_present_i),
    .rdata(rd_data)
  );

  assign irq_o = views[0].irq | views[1].irq;

  // R10
  irq_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    |irq_lvl_i |=> irq_o);

  // R10
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_lvl_i == 2'b00 |=> !irq_o);

  // R13
  rst_outputs_chk: assert property (@(posedge clk)
    !rst_n |=> chan_rst_o == 2'b11);
endmodule

// File: tb/dcr_top_bench.sv
module dcr_top_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, rsp_ready = 1'b1;
  logic [8:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        req_ready, rsp_valid, irq_o;
  logic [31:0] rsp_data;
  logic [1:0]  irq_lvl = 2'b00, dev_present = 2'b00, eng_we = 2'b00;
  logic [5:0]  eng_val = '0;
  logic [15:0] dma_cmd;
  logic [1:0]  chan_rst;

  int checks = 0, errors = 0;
  bit stall_en = 1'b0;
  logic [31:0] exp_q[$];
  string tag_q[$];

  always #5 clk = ~clk;

  dcr_top u_dcr_top (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .irq_lvl_i(irq_lvl), .dev_present_i(dev_present), .eng_we_i(eng_we),
    .eng_val_i(eng_val), .dma_cmd_o(dma_cmd), .chan_rst_o(chan_rst),
    .irq_o(irq_o)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic access(input bit wr, input logic [8:0] a, input logic [31:0] d,
                        input logic [31:0] exp, input string tag);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    if (!wr) begin
      exp_q.push_back(exp);
      tag_q.push_back(tag);
    end
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wr(input logic [8:0] a, input logic [31:0] d);
    access(1'b1, a, d, '0, "");
  endtask

  task automatic rd(input logic [8:0] a, input logic [31:0] exp, input string tag);
    access(1'b0, a, '0, exp, tag);
  endtask

  task automatic engine(input int ch, input logic [2:0] v);
    @(negedge clk);
    eng_we[ch] = 1'b1; eng_val[3*ch +: 3] = v;
    @(negedge clk);
    eng_we = 2'b00; eng_val = '0;
  endtask

  task automatic drain;
    while (exp_q.size() != 0) @(negedge clk);
  endtask

  // monitor: a transfer completes on the edge after a negedge with valid && ready
  always @(negedge clk) begin
    if (rsp_valid && rsp_ready) begin
      if (exp_q.size() == 0) begin
        check("R1 unexpected response", rsp_data, 32'hxxxxxxxx);
      end else begin
        check(tag_q.pop_front(), rsp_data, exp_q.pop_front());
      end
    end
  end

  // back-pressure pattern: ready low two cycles out of five
  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk); #1;
      cyc++;
      rsp_ready <= !stall_en || (cyc % 5) >= 2;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R13 chan_rst in reset", {30'b0, chan_rst}, 32'h3);
    rst_n = 1'b1;
    @(negedge clk);
    check("R13 chan_rst after reset", {30'b0, chan_rst}, 32'h0);
    check("R13 irq_o after reset", {31'b0, irq_o}, 32'h0);
    rd(9'h000, 32'h0, "R13 cmd0 reset");
    rd(9'h00A, 32'h0, "R13 stat1 reset");
    rd(9'h100, 32'h0, "R13 sctl0 reset");
    rd(9'h0A0, 32'h6515_0000, "R9 conf0 reset");
    rd(9'h0E0, 32'h6515_0000, "R9 conf1 reset");

    // R4 command and software bytes
    wr(9'h000, 32'h0000_0009);
    check("R4 dma_cmd_o", {16'b0, dma_cmd}, 32'h0009);
    rd(9'h000, 32'h09, "R4 cmd0");
    wr(9'h001, 32'hFFFF_FFFF);
    rd(9'h001, 32'h3F, "R3 swd0 mask");
    wr(9'h011, 32'h15);
    rd(9'h001, 32'h15, "R4 swd0 via mirror");

    // R14 engine events and R2 status write rules
    engine(0, 3'b111);
    rd(9'h002, 32'h07, "R14 engine set");
    wr(9'h002, 32'hFF);
    rd(9'h002, 32'h61, "R2 status write ff");
    engine(0, 3'b110);
    rd(9'h002, 32'h66, "R14 engine active clear");
    wr(9'h012, 32'h04);
    rd(9'h002, 32'h02, "R2 partial w1c via mirror");

    // channel 1
    wr(9'h018, 32'h01);
    check("R4 dma_cmd_o ch1", {16'b0, dma_cmd}, 32'h0109);
    wr(9'h019, 32'h2A);
    rd(9'h009, 32'h2A, "R4 swd1 via mirror");
    engine(1, 3'b100);
    wr(9'h01A, 32'h20);
    rd(9'h00A, 32'h24, "R2 status1 keep bit2");

    // R9 and R10 interrupt flags
    @(negedge clk); irq_lvl = 2'b10;
    @(negedge clk);
    check("R10 irq_o set", {31'b0, irq_o}, 32'h1);
    rd(9'h010, 32'h2402_4049, "R5 summary word");
    rd(9'h018, 32'h0024_0011, "R6 channel1 word");
    rd(9'h0E0, 32'h6515_0800, "R9 conf1 flag");
    rd(9'h0A0, 32'h6515_0000, "R9 conf0 no flag");
    @(negedge clk); irq_lvl = 2'b01;
    @(negedge clk);
    check("R10 irq_o ch0", {31'b0, irq_o}, 32'h1);
    rd(9'h010, 32'h2402_4019, "R5 summary ch0 flag");
    @(negedge clk); irq_lvl = 2'b00;
    @(negedge clk);
    check("R10 irq_o clear", {31'b0, irq_o}, 32'h0);

    // R7 serial control and reset pulse
    wr(9'h100, 32'hFFFF_F001);
    check("R7 pulse ch0", {30'b0, chan_rst}, 32'h1);
    @(negedge clk);
    check("R7 pulse ends", {30'b0, chan_rst}, 32'h0);
    rd(9'h100, 32'h001, "R7 sctl0 mask");
    wr(9'h180, 32'h0000_0ABE);
    check("R7 no pulse", {30'b0, chan_rst}, 32'h0);
    rd(9'h180, 32'hABE, "R7 sctl1");

    // R8 interrupt enable
    wr(9'h148, 32'hFFFF_0000);
    rd(9'h148, 32'h3EED_0000, "R8 sien0");
    wr(9'h1C8, 32'h1234_5678);
    rd(9'h1C8, 32'h1224_0000, "R8 sien1");

    // R11 serial status
    dev_present = 2'b01;
    rd(9'h104, 32'h113, "R11 present ch0");
    rd(9'h184, 32'h0, "R11 absent ch1");

    // R12 reserved and unmapped
    wr(9'h003, 32'hFF);
    wr(9'h040, 32'hFFFF_FFFF);
    wr(9'h1FF, 32'hFFFF_FFFF);
    rd(9'h003, 32'h0, "R12 reserved0");
    rd(9'h00B, 32'h0, "R12 reserved1");
    rd(9'h040, 32'h0, "R12 unmapped");
    rd(9'h000, 32'h09, "R12 cmd0 untouched");
    rd(9'h001, 32'h15, "R12 swd0 untouched");

    // R1 back-to-back reads under back-pressure
    drain();
    stall_en = 1'b1;
    for (int i = 0; i < 4; i++) begin
      rd(9'h001, 32'h15, "R1 backpressure swd0");
      rd(9'h009, 32'h2A, "R1 backpressure swd1");
    end
    wr(9'h001, 32'h0C);
    rd(9'h001, 32'h0C, "R1 write then read");
    drain();
    stall_en = 1'b0;
    repeat (3) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule